// File: doc/BRIEF.md
# Command Bus Handover Switch

This block sits between a DRAM memory controller, a payload sequencer and the DRAM command interface. In normal operation the controller drives every phase of the command bus. When software asks for the sequencer to run, the switch does not hand over at once. It stays armed until the controller has just issued a refresh, so the memory is freshly refreshed when the sequencer takes over. One clock after that refresh, the sequencer owns the bus. The controller's own commands are then dropped, and its refresh timer is held in reset. When the sequencer reports that it has finished, the bus goes back to the controller on the next clock.

A refresh counter watches phase 0 of the outgoing bus. It therefore counts refreshes from both owners. A held copy of the count is captured at the handover. Software can capture it again at any time with an update strobe, for example to see the refreshes that a payload added. A programmable threshold can delay the handover until the live count has reached a chosen value. With the threshold at zero, the first refresh after the request is used.

Top module: `dfi_handover_switch`

## Requirements
- R1: After reset the controller owns the bus, the held count reads 0, and the refresh-timer reset output is low.
- R2: A start request in the idle state arms the switch. While armed, the controller keeps the bus. The sequencer owns the bus from the clock that follows the cycle in which a refresh appears on phase 0 and meets the threshold of R7.
- R3: A refresh is phase 0 of the outgoing bus with cs_n, ras_n and cas_n low and we_n high. Each phase holds the command bits in bits [3:0] as {cs_n, ras_n, cas_n, we_n}, with the address above them. The same pattern on another phase, or any other pattern on phase 0, is not a refresh.
- R4: The live count rises by one for each refresh on the outgoing bus, whichever side drove it. It saturates at its maximum value.
- R5: At the handover the held count takes the live count, including the refresh that triggered the handover.
- R6: An update pulse loads the held count with the live count, including any refresh in the same cycle. Otherwise the held count does not change.
- R7: While armed, a refresh triggers the handover only if the live count after that refresh is at least the threshold `switch_at`. A threshold of 0 means the first refresh.
- R8: While the sequencer owns the bus, every phase of the outgoing bus equals the sequencer's bus, the controller's commands have no effect, and `ctl_tmr_rst` is high.
- R9: A done pulse while the sequencer owns the bus returns the bus to the controller on the next clock. A done pulse in any other state is ignored. A start request in any state other than idle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request to hand the bus to the sequencer |
| seq_done | input | 1 | One-cycle pulse: the sequencer has finished |
| switch_at | input | CNT_W | Refresh-count threshold for the handover |
| cnt_update | input | 1 | One-cycle pulse: load the held count with the live count |
| ctl_bus | input | NPHASES*(ADDR_W+4) | Controller command bus, all phases |
| seq_bus | input | NPHASES*(ADDR_W+4) | Sequencer command bus, all phases |
| dram_bus | output | NPHASES*(ADDR_W+4) | Command bus to the DRAM interface |
| seq_owner | output | 1 | High while the sequencer owns the bus |
| ctl_tmr_rst | output | 1 | Holds the controller's refresh timer in reset |
| ref_count | output | CNT_W | Held refresh count |

## Verification
A wrong ownership state shows at once on `dram_bus`: the mux follows the state in the same cycle, so the wrong source's commands appear on the first clock after the bad transition. A handover that ignores the refresh boundary or the threshold shows as `seq_owner` rising one clock too early or too late relative to a known refresh. A live counter that misses refreshes or double counts stays hidden until the next capture. The bench therefore pulses the update strobe after each payload, so a miscount shows on `ref_count` one clock later.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [1:0] {
        OWN_CTL   = 2'd0,
        OWN_ARMED = 2'd1,
        OWN_SEQ   = 2'd2
    } owner_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_t;

    function automatic logic is_refresh(input cmd_t c);
        return !c.cs_n && !c.ras_n && !c.cas_n && c.we_n;
    endfunction

endpackage

// File: rtl/hs_cmd_mux.sv
module hs_cmd_mux
    import hs_pkg::*;
#(
    parameter int NPHASES = 4,
    parameter int PH_W    = 21,
    localparam int BUS_W  = NPHASES * PH_W
) (
    input  logic             sel_seq,
    input  logic [BUS_W-1:0] ctl_bus,
    input  logic [BUS_W-1:0] seq_bus,
    output logic [BUS_W-1:0] out_bus,
    output logic             ref_hit
);

    for (genvar p = 0; p < NPHASES; p++) begin : g_phase
        assign out_bus[p*PH_W +: PH_W] = sel_seq ? seq_bus[p*PH_W +: PH_W]
                                                 : ctl_bus[p*PH_W +: PH_W];
    end

    // only phase 0 carries refresh detection
    assign ref_hit = is_refresh(cmd_t'(out_bus[CMD_W-1:0]));

endmodule

// File: rtl/hs_refresh_counter.sv
module hs_refresh_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_hit,
    input  logic             capture,
    output logic [CNT_W-1:0] live_q,
    output logic [CNT_W-1:0] live_nx,
    output logic [CNT_W-1:0] held_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_comb begin
        live_nx = live_q;
        if (ref_hit && (live_q != CNT_MAX)) begin
            live_nx = live_q + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            held_q <= '0;
        end else begin
            live_q <= live_nx;
            if (capture) begin
                held_q <= live_nx;
            end
        end
    end

    // R4: the count moves by at most one per clock
    p_step_one_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((live_q == $past(live_q)) || (live_q == $past(live_q) + CNT_ONE)));

    // R4: saturation holds
    p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (live_q == CNT_MAX) |=> (live_q == CNT_MAX));

    // R6: held count only moves when captured
    p_held_still_r6: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(held_q));

endmodule

// File: rtl/hs_owner_fsm.sv
module hs_owner_fsm
    import hs_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             seq_done,
    input  logic             ref_hit,
    input  logic [CNT_W-1:0] live_nx,
    input  logic [CNT_W-1:0] switch_at,
    output logic             take,
    output logic             seq_own
);

    owner_e st_q;

    always_comb begin
        take = (st_q == OWN_ARMED) && ref_hit && (live_nx >= switch_at);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= OWN_CTL;
        end else begin
            unique case (st_q)
                OWN_CTL:   if (start_req) st_q <= OWN_ARMED;
                OWN_ARMED: if (take)      st_q <= OWN_SEQ;
                OWN_SEQ:   if (seq_done)  st_q <= OWN_CTL;
                default:                  st_q <= OWN_CTL;
            endcase
        end
    end

    assign seq_own = (st_q == OWN_SEQ);

    // R2: ownership appears only right after a refresh on the bus
    p_take_after_ref_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_own) |-> $past(ref_hit));

    // R2: armed without refresh keeps the controller
    p_armed_holds_r2: assert property (@(posedge clk) disable iff (rst)
        ((st_q == OWN_ARMED) && !ref_hit) |=> !seq_own);

    // R9: done hands the bus back on the next clock
    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        (seq_own && seq_done) |=> !seq_own);

    // R9: idle never jumps straight to sequencer ownership
    p_no_skip_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q == OWN_CTL) |=> !seq_own);

endmodule

// File: rtl/dfi_handover_switch.sv
module dfi_handover_switch
    import hs_pkg::*;
#(
    parameter int NPHASES = 4,
    parameter int ADDR_W  = 17,
    parameter int CNT_W   = 16,
    localparam int PH_W   = ADDR_W + CMD_W,
    localparam int BUS_W  = NPHASES * PH_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             seq_done,
    input  logic [CNT_W-1:0] switch_at,
    input  logic             cnt_update,
    input  logic [BUS_W-1:0] ctl_bus,
    input  logic [BUS_W-1:0] seq_bus,
    output logic [BUS_W-1:0] dram_bus,
    output logic             seq_owner,
    output logic             ctl_tmr_rst,
    output logic [CNT_W-1:0] ref_count
);

    logic             ref_hit;
    logic             take;
    logic [CNT_W-1:0] live_q;
    logic [CNT_W-1:0] live_nx;

    hs_cmd_mux #(
        .NPHASES (NPHASES),
        .PH_W    (PH_W)
    ) u_mux (
        .sel_seq (seq_owner),
        .ctl_bus (ctl_bus),
        .seq_bus (seq_bus),
        .out_bus (dram_bus),
        .ref_hit (ref_hit)
    );

    hs_refresh_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .ref_hit (ref_hit),
        .capture (take || cnt_update),
        .live_q  (live_q),
        .live_nx (live_nx),
        .held_q  (ref_count)
    );

    hs_owner_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .seq_done  (seq_done),
        .ref_hit   (ref_hit),
        .live_nx   (live_nx),
        .switch_at (switch_at),
        .take      (take),
        .seq_own   (seq_owner)
    );

    assign ctl_tmr_rst = seq_owner;

    // R5: held count equals live count on the first owned cycle
    p_latch_at_take_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_owner) |-> (ref_count == live_q));

    // R7: handover never precedes the threshold
    p_threshold_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_owner) |-> (live_q >= switch_at));

endmodule

// File: tb/dfi_handover_switch_test.sv
module dfi_handover_switch_test;

    localparam int NPH = 4;
    localparam int AW  = 4;
    localparam int CW  = 4;
    localparam int BW  = NPH * (AW + 4);
    localparam logic [BW-1:0] IDLE_BUS = {NPH{8'h0F}};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_req = 1'b0;
    logic          seq_done = 1'b0;
    logic [CW-1:0] switch_at = '0;
    logic          cnt_update = 1'b0;
    logic [BW-1:0] ctl_bus = IDLE_BUS;
    logic [BW-1:0] seq_bus = IDLE_BUS;
    logic [BW-1:0] dram_bus;
    logic          seq_owner;
    logic          ctl_tmr_rst;
    logic [CW-1:0] ref_count;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_live = 0;

    always #10 clk = ~clk;

    dfi_handover_switch #(.NPHASES(NPH), .ADDR_W(AW), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .start_req(start_req), .seq_done(seq_done),
        .switch_at(switch_at), .cnt_update(cnt_update), .ctl_bus(ctl_bus),
        .seq_bus(seq_bus), .dram_bus(dram_bus), .seq_owner(seq_owner),
        .ctl_tmr_rst(ctl_tmr_rst), .ref_count(ref_count)
    );

    function automatic logic [BW-1:0] put(input int ph, input logic [7:0] v, input logic [BW-1:0] base);
        logic [BW-1:0] b = base;
        b[ph*8 +: 8] = v;
        return b;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic bump();
        if (exp_live < (1 << CW) - 1) exp_live++;
    endtask

    task automatic ctl_ref();
        ctl_bus = put(0, 8'h01, IDLE_BUS);
        cyc();
        ctl_bus = IDLE_BUS;
    endtask

    task automatic seq_ref();
        seq_bus = put(0, 8'h01, IDLE_BUS);
        cyc();
        seq_bus = IDLE_BUS;
    endtask

    task automatic pulse_start();
        start_req = 1'b1; cyc(); start_req = 1'b0;
    endtask

    task automatic pulse_done();
        seq_done = 1'b1; cyc(); seq_done = 1'b0;
    endtask

    task automatic pulse_update();
        cnt_update = 1'b1; cyc(); cnt_update = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; repeat (3) cyc(); rst = 1'b0; cyc();
        chk(seq_owner == 1'b0, "R1", "owner after reset", seq_owner, 0);
        chk(ctl_tmr_rst == 1'b0, "R1", "timer reset after reset", ctl_tmr_rst, 0);
        chk(ref_count == 0, "R1", "held count after reset", ref_count, 0);
    endtask

    task automatic t_basic();
        ctl_ref(); bump();
        ctl_ref(); bump();
        chk(ref_count == 0, "R6", "held count without update", ref_count, 0);
        pulse_start();
        // R3: refresh on phase 1 is not a refresh
        ctl_bus = put(1, 8'h01, IDLE_BUS); cyc(); ctl_bus = IDLE_BUS;
        chk(seq_owner == 1'b0, "R3", "phase 1 refresh ignored", seq_owner, 0);
        // R3: phase 0 with we_n low is not a refresh
        ctl_bus = put(0, 8'h00, IDLE_BUS); cyc(); ctl_bus = IDLE_BUS;
        chk(seq_owner == 1'b0, "R3", "near-miss pattern ignored", seq_owner, 0);
        #1;
        chk(dram_bus == ctl_bus, "R2", "armed keeps controller bus", dram_bus, ctl_bus);
        ctl_ref(); bump();
        chk(seq_owner == 1'b1, "R2", "owner one clock after refresh", seq_owner, 1);
        chk(ctl_tmr_rst == 1'b1, "R8", "timer reset while owned", ctl_tmr_rst, 1);
        chk(ref_count == CW'(exp_live), "R5", "held count at handover", ref_count, exp_live);
        // R8: controller refresh while sequencer owns has no effect
        seq_bus = {8'h3A, 8'h5B, 8'h13, 8'h23};
        ctl_bus = put(0, 8'h01, IDLE_BUS);
        #1;
        chk(dram_bus == seq_bus, "R8", "bus follows sequencer", dram_bus, seq_bus);
        cyc();
        ctl_bus = IDLE_BUS; seq_bus = IDLE_BUS;
        seq_ref(); bump();
        chk(ref_count == CW'(exp_live - 1), "R6", "held count unchanged before update", ref_count, exp_live - 1);
        pulse_update();
        chk(ref_count == CW'(exp_live), "R4", "payload refresh counted", ref_count, exp_live);
        pulse_done();
        chk(seq_owner == 1'b0, "R9", "controller back after done", seq_owner, 0);
        chk(ctl_tmr_rst == 1'b0, "R8", "timer reset released", ctl_tmr_rst, 0);
        #1;
        chk(dram_bus == ctl_bus, "R9", "bus follows controller", dram_bus, ctl_bus);
    endtask

    task automatic t_threshold();
        switch_at = CW'(exp_live + 3);
        pulse_start();
        ctl_ref(); bump();
        chk(seq_owner == 1'b0, "R7", "below threshold (1)", seq_owner, 0);
        ctl_ref(); bump();
        chk(seq_owner == 1'b0, "R7", "below threshold (2)", seq_owner, 0);
        ctl_ref(); bump();
        chk(seq_owner == 1'b1, "R7", "handover at threshold", seq_owner, 1);
        chk(ref_count == switch_at, "R5", "held count equals threshold", ref_count, switch_at);
        seq_ref(); bump();
        pulse_done();
        pulse_update();
        chk(ref_count == switch_at + CW'(1), "R6", "threshold plus payload refresh", ref_count, switch_at + 1);
        switch_at = '0;
    endtask

    task automatic t_ignored();
        pulse_done();
        cyc();
        chk(seq_owner == 1'b0, "R9", "done in idle ignored", seq_owner, 0);
        ctl_ref(); bump();
        chk(seq_owner == 1'b0, "R2", "refresh without start", seq_owner, 0);
        pulse_start();
        ctl_ref(); bump();
        chk(seq_owner == 1'b1, "R7", "threshold 0 takes first refresh", seq_owner, 1);
        pulse_start();
        pulse_done();
        ctl_ref(); bump();
        chk(seq_owner == 1'b0, "R9", "start while owned ignored", seq_owner, 0);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 6; i++) begin
            ctl_ref(); bump();
        end
        pulse_update();
        chk(ref_count == CW'(exp_live), "R4", "count saturates", ref_count, exp_live);
        switch_at = CW'(3);
        pulse_start();
        ctl_ref(); bump();
        chk(seq_owner == 1'b1, "R7", "count already past threshold", seq_owner, 1);
        chk(ref_count == CW'(exp_live), "R5", "held count saturated at handover", ref_count, exp_live);
        pulse_done();
        switch_at = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cyc();
        t_reset();
        t_basic();
        t_threshold();
        t_ignored();
        t_saturate();
        repeat (2) cyc();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule